// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block is the digital timing core of a PWM current regulator for one bridge of a stepper driver. Each chopping cycle starts with the bridge conducting. For a short blanking window after the bridge switches on, the sense comparator is ignored, so that switching transients cannot cause a false trip. When blanking ends, the block watches the comparator. The first trip it sees turns the bridge off for a fixed off-time. After the off-time the bridge turns on again and the cycle repeats.

Two inputs set the length of the off-time and the decay used during it: a two-way source select and a full-step flag. With a fixed source, the off-time is a constant 30 ticks. Decay is mixed, or slow when the translator is in full step. With the external-count source, the off-time is a programmed number of ticks and decay is always mixed. In mixed decay, the first quarter of the off-time uses fast decay and the rest uses slow decay. A disable input forces the bridge off and restarts the chopper at a fresh on-phase.

All timing is counted in ticks of `TICK_DIV` clock cycles each. With the default value, one tick is 1 µs at a 100 MHz clock. Blanking lasts `BLANK_TICKS` ticks.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is asserted, the block is at the start of an on-phase: bridge_on=1, blank_active=1, fast_phase=0, decay_mixed=0.
- R2: Each on-phase begins with blank_active high for exactly BLANK_TICKS*TICK_DIV cycles. A trip during that window has no effect, and the bridge stays on.
- R3: After blanking, trip_in is sampled on every clock edge. The first edge that sees it high turns bridge_on low in the next cycle. With trip held high, an on-phase lasts BLANK_TICKS*TICK_DIV+1 cycles.
- R4: With toff_src = 2'b00 or 2'b01 (fixed source) and full_step=0, the off-time is FIXED_OFF_TICKS*TICK_DIV cycles and decay_mixed=1.
- R5: With a fixed source and full_step=1, the off-time is still FIXED_OFF_TICKS*TICK_DIV cycles, but decay_mixed=0 and fast_phase stays low.
- R6: With toff_src = 2'b10 or 2'b11 (external count), the off-time is toff_count*TICK_DIV cycles, with a count of 0 treated as 1. decay_mixed=1 whatever full_step is.
- R7: In a mixed-decay off-time, fast_phase is high for the first floor(L/4) ticks of an L-tick off-time and low for the rest. fast_phase is never high while the bridge is on or in slow decay.
- R8: A trip during the off-time has no effect. When the off-time ends, the bridge turns back on with a new blanking window.
- R9: While chop_disable is high, bridge_on is 0 in the same cycle. When it goes low, a new on-phase with full blanking starts.
- R10: toff_src, toff_count and full_step are captured at the trip edge. Changing them during an off-time does not change that off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chop_disable | input | 1 | Forces the bridge off and restarts the chopper |
| trip_in | input | 1 | Sense comparator trip, active high |
| toff_src | input | 2 | Off-time source: 00/01 fixed, 10/11 external count |
| toff_count | input | CNT_W | Off-time in ticks for the external-count source |
| full_step | input | 1 | Translator is in full-step mode |
| bridge_on | output | 1 | Bridge conducts |
| decay_mixed | output | 1 | Decay mode of the current off-time: 1 mixed, 0 slow |
| fast_phase | output | 1 | Fast-decay part of a mixed off-time |
| blank_active | output | 1 | Comparator is blanked |

## Verification
The case that matters most is the last cycle of blanking while the comparator is already high. Blanking expiry and trip detection then compete in one cycle. The bench holds trip_in high across whole on-phases and requires the on-phase to last exactly one cycle longer than blanking: the trip in the final blanking cycle must be ignored, and the trip in the next cycle must be taken. The bench also asserts chop_disable in the middle of an off-time, so that the off-time timer and the restart act in the same cycle. It then checks that the bridge is off at once and that a full blanking window follows the release.

// File: rtl/chop_pkg.sv
package chop_pkg;
   typedef enum logic [1:0] {
      PH_BLANK = 2'd0,
      PH_SENSE = 2'd1,
      PH_OFF   = 2'd2
   } chop_phase_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/chop_tick_timer.sv
module chop_tick_timer #(
   parameter int TICK_DIV = 100,
   parameter int TW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [TW-1:0] len,
   output logic [TW-1:0] tick_idx,
   output logic          done
);
   localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   logic          tick_end;
   logic [TW-1:0] ticks_q;

   generate
      if (TICK_DIV == 1) begin : g_no_prescale
         assign tick_end = 1'b1;
      end else begin : g_prescale
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              pre_q <= '0;
            else if (restart)                        pre_q <= '0;
            else if (pre_q == PW'(TICK_DIV - 1))     pre_q <= '0;
            else                                     pre_q <= pre_q + PW'(1);
         end
         assign tick_end = (pre_q == PW'(TICK_DIV - 1));

         a_r2_prescale_range: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= PW'(TICK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ticks_q <= '0;
      else if (restart)  ticks_q <= '0;
      else if (tick_end) ticks_q <= ticks_q + TW'(1);
   end

   assign tick_idx = ticks_q;
   assign done     = tick_end && (ticks_q == len - TW'(1));

   // R8: a running phase never counts past its programmed length
   a_r8_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (tick_idx < len));
endmodule

// File: rtl/chop_off_select.sv
module chop_off_select #(
   parameter int CNT_W           = 10,
   parameter int FIXED_OFF_TICKS = 30,
   parameter int TW              = 10
) (
   input  logic [1:0]       toff_src,
   input  logic [CNT_W-1:0] toff_count,
   input  logic             full_step,
   output logic [TW-1:0]    off_len,
   output logic             mixed
);
   logic [TW-1:0] ext_len;

   generate
      if (TW > CNT_W) begin : g_widen
         assign ext_len = {{(TW-CNT_W){1'b0}}, toff_count};
      end else begin : g_same
         assign ext_len = toff_count;
      end
   endgenerate

   always_comb begin
      if (toff_src[1]) begin
         off_len = (ext_len == '0) ? TW'(1) : ext_len;
         mixed   = 1'b1;
      end else begin
         off_len = TW'(FIXED_OFF_TICKS);
         mixed   = !full_step;
      end
   end
endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
   import chop_pkg::*;
#(
   parameter int BLANK_TICKS = 1,
   parameter int TW          = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dis,
   input  logic          trip,
   input  logic [TW-1:0] sel_len,
   input  logic          sel_mixed,
   input  logic          done,
   output chop_phase_t   phase,
   output logic          restart,
   output logic [TW-1:0] timer_len,
   output logic [TW-1:0] off_len_q,
   output logic          mixed_q
);
   chop_phase_t phase_q, phase_d;
   logic        take_trip;

   assign take_trip = (phase_q == PH_SENSE) && trip && !dis;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_BLANK: if (done) phase_d = PH_SENSE;
         PH_SENSE: if (trip) phase_d = PH_OFF;
         PH_OFF:   if (done) phase_d = PH_BLANK;
         default:  phase_d = PH_BLANK;
      endcase
      if (dis) phase_d = PH_BLANK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_BLANK;
      else        phase_q <= phase_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_len_q <= TW'(1);
         mixed_q   <= 1'b0;
      end else if (take_trip) begin
         off_len_q <= sel_len;
         mixed_q   <= sel_mixed;
      end
   end

   assign restart   = dis || (phase_d != phase_q) || (phase_q == PH_SENSE);
   assign timer_len = (phase_q == PH_OFF) ? off_len_q : TW'(BLANK_TICKS);
   assign phase     = phase_q;

   a_r2_blank_ignores_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_BLANK) && trip && !dis |=> phase_q != PH_OFF);
   a_r3_trip_sensed: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SENSE) && trip && !dis |=> phase_q == PH_OFF);
   a_r8_off_ignores_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OFF) && !done && !dis |=> phase_q == PH_OFF);
   a_r9_disable_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      dis |=> phase_q == PH_BLANK);
   a_r10_settings_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_OFF) |=> $stable(off_len_q) && $stable(mixed_q));
endmodule

// File: rtl/offtime_chopper.sv
module offtime_chopper
   import chop_pkg::*;
#(
   parameter int TICK_DIV        = 100,
   parameter int BLANK_TICKS     = 1,
   parameter int FIXED_OFF_TICKS = 30,
   parameter int CNT_W           = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chop_disable,
   input  logic             trip_in,
   input  logic [1:0]       toff_src,
   input  logic [CNT_W-1:0] toff_count,
   input  logic             full_step,
   output logic             bridge_on,
   output logic             decay_mixed,
   output logic             fast_phase,
   output logic             blank_active
);
   localparam int TW = max3(CNT_W, $clog2(FIXED_OFF_TICKS + 1), $clog2(BLANK_TICKS + 1));

   generate
      if (TICK_DIV < 1)        begin : g_bad_div   $error("TICK_DIV must be at least 1");        end
      if (BLANK_TICKS < 1)     begin : g_bad_blank $error("BLANK_TICKS must be at least 1");     end
      if (FIXED_OFF_TICKS < 1) begin : g_bad_fixed $error("FIXED_OFF_TICKS must be at least 1"); end
      if (CNT_W < 1)           begin : g_bad_cnt   $error("CNT_W must be at least 1");           end
   endgenerate

   chop_phase_t   phase;
   logic          restart, done;
   logic [TW-1:0] tick_idx, timer_len, off_len_q, sel_len;
   logic          sel_mixed, mixed_q;
   logic [TW-1:0] fast_len;

   chop_off_select #(
      .CNT_W(CNT_W), .FIXED_OFF_TICKS(FIXED_OFF_TICKS), .TW(TW)
   ) u_sel (
      .toff_src(toff_src), .toff_count(toff_count), .full_step(full_step),
      .off_len(sel_len), .mixed(sel_mixed)
   );

   chop_phase_ctrl #(.BLANK_TICKS(BLANK_TICKS), .TW(TW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .dis(chop_disable), .trip(trip_in),
      .sel_len(sel_len), .sel_mixed(sel_mixed), .done(done),
      .phase(phase), .restart(restart), .timer_len(timer_len),
      .off_len_q(off_len_q), .mixed_q(mixed_q)
   );

   chop_tick_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(restart), .len(timer_len),
      .tick_idx(tick_idx), .done(done)
   );

   assign fast_len     = off_len_q >> 2;
   assign bridge_on    = (phase != PH_OFF) && !chop_disable;
   assign blank_active = (phase == PH_BLANK) && !chop_disable;
   assign decay_mixed  = mixed_q;
   assign fast_phase   = (phase == PH_OFF) && mixed_q && !chop_disable && (tick_idx < fast_len);

   // R7: fast decay only inside a mixed off-time
   a_r7_fast_in_mixed: assert property (@(posedge clk) disable iff (!rst_n)
      fast_phase |-> decay_mixed && !bridge_on);
   // R9: release of disable always lands at the start of blanking
   a_r9_release_blanks: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chop_disable) |-> blank_active && bridge_on);
endmodule

// File: tb/test_offtime_chopper.sv
module test_offtime_chopper;
   localparam int DIV   = 8;
   localparam int BLK   = 1;
   localparam int FIX   = 30;
   localparam int LIMIT = 5000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       chop_disable = 1'b0;
   logic       trip_in = 1'b0;
   logic [1:0] toff_src = 2'b00;
   logic [9:0] toff_count = 10'd0;
   logic       full_step = 1'b0;
   logic       bridge_on, decay_mixed, fast_phase, blank_active;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   offtime_chopper #(.TICK_DIV(DIV), .BLANK_TICKS(BLK), .FIXED_OFF_TICKS(FIX), .CNT_W(10))
   i_offtime_chopper (
      .clk(clk), .rst_n(rst_n), .chop_disable(chop_disable), .trip_in(trip_in),
      .toff_src(toff_src), .toff_count(toff_count), .full_step(full_step),
      .bridge_on(bridge_on), .decay_mixed(decay_mixed), .fast_phase(fast_phase),
      .blank_active(blank_active)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic nedge();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_bridge(input bit lvl);
      int n = 0;
      nedge();
      while (bridge_on != lvl && n < LIMIT) begin n++; nedge(); end
      chk(n < LIMIT, "wait for bridge level", n, LIMIT);
   endtask

   // measures one complete off-time plus the on-phase after it, trip held high
   task automatic measure(input int exp_off, input int exp_fast, input bit exp_mix, input string tag);
      int off = 0, fast = 0, mixbad = 0, blank = 0, on = 0;
      wait_bridge(1'b1);
      wait_bridge(1'b0);
      while (!bridge_on && off < LIMIT) begin
         off++;
         if (fast_phase) fast++;
         if (decay_mixed != exp_mix) mixbad++;
         nedge();
      end
      while (blank_active && blank < LIMIT) begin blank++; on++; nedge(); end
      while (bridge_on && on < LIMIT) begin on++; nedge(); end
      chk(off == exp_off, {tag, " off length"}, off, exp_off);
      chk(fast == exp_fast, {"R7 fast part, ", tag}, fast, exp_fast);
      chk(mixbad == 0, {tag, " decay mode"}, mixbad, 0);
      chk(blank == BLK*DIV, "R8/R2 blank after off", blank, BLK*DIV);
      chk(on == BLK*DIV + 1, "R3 on length with trip held", on, BLK*DIV + 1);
   endtask

   task automatic t_reset();
      chk(bridge_on == 1'b1, "R1 bridge_on in reset", bridge_on, 1);
      chk(blank_active == 1'b1, "R1 blank_active in reset", blank_active, 1);
      chk(fast_phase == 1'b0, "R1 fast_phase in reset", fast_phase, 0);
      chk(decay_mixed == 1'b0, "R1 decay_mixed in reset", decay_mixed, 0);
   endtask

   task automatic t_fixed();
      toff_src = 2'b00; full_step = 1'b0; trip_in = 1'b1;
      measure(FIX*DIV, (FIX/4)*DIV, 1'b1, "R4 fixed 00");
      toff_src = 2'b01;
      measure(FIX*DIV, (FIX/4)*DIV, 1'b1, "R4 fixed 01");
   endtask

   task automatic t_full_step();
      toff_src = 2'b01; full_step = 1'b1;
      measure(FIX*DIV, 0, 1'b0, "R5 fixed full step");
      full_step = 1'b0;
   endtask

   task automatic t_external();
      toff_src = 2'b10; toff_count = 10'd12;
      measure(12*DIV, 3*DIV, 1'b1, "R6 external 12");
      toff_src = 2'b11; toff_count = 10'd5; full_step = 1'b1;
      measure(5*DIV, 1*DIV, 1'b1, "R6 external 5 full step");
      toff_count = 10'd0; full_step = 1'b0;
      measure(1*DIV, 0, 1'b1, "R6 external zero");
   endtask

   task automatic t_blank_ignore();
      int hi = 0;
      trip_in = 1'b0;
      wait_bridge(1'b1);
      chk(blank_active == 1'b1, "R2 blank at on start", blank_active, 1);
      trip_in = 1'b1;
      repeat (5) nedge();
      trip_in = 1'b0;
      repeat (40) begin nedge(); if (bridge_on) hi++; end
      chk(hi == 40, "R2 trip in blanking ignored", hi, 40);
      trip_in = 1'b1;
      nedge(); nedge();
      chk(bridge_on == 1'b0, "R3 late trip turns bridge off", bridge_on, 0);
   endtask

   task automatic t_latch();
      int off = 1;
      toff_src = 2'b00; full_step = 1'b0; trip_in = 1'b1;
      wait_bridge(1'b1);
      wait_bridge(1'b0);
      toff_src = 2'b10; toff_count = 10'd2; full_step = 1'b1;
      nedge();
      while (!bridge_on && off < LIMIT) begin off++; nedge(); end
      chk(off == FIX*DIV, "R10 off-time kept after change", off, FIX*DIV);
      measure(2*DIV, 0, 1'b1, "R10 new setting next cycle");
      toff_src = 2'b00; full_step = 1'b0;
   endtask

   task automatic t_disable();
      int low = 0, blank = 0;
      trip_in = 1'b1; toff_src = 2'b00;
      wait_bridge(1'b1);
      wait_bridge(1'b0);
      repeat (10) nedge();
      chop_disable = 1'b1;
      #1;
      chk(bridge_on == 1'b0, "R9 bridge off with disable", bridge_on, 0);
      chk(fast_phase == 1'b0, "R9 no fast decay with disable", fast_phase, 0);
      repeat (20) begin nedge(); if (!bridge_on) low++; end
      chk(low == 20, "R9 bridge stays off", low, 20);
      chop_disable = 1'b0;
      #1;
      chk(bridge_on == 1'b1, "R9 bridge on after release", bridge_on, 1);
      while (blank_active && blank < LIMIT) begin blank++; nedge(); end
      chk(blank == BLK*DIV, "R9 full blanking after release", blank, BLK*DIV);
      nedge();
      chk(bridge_on == 1'b0, "R3 trip right after release blanking", bridge_on, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) nedge();
      t_reset();
      rst_n = 1'b1;
      t_fixed();
      t_full_step();
      t_external();
      t_blank_ignore();
      t_latch();
      t_disable();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule